// File: doc/BRIEF.md
# Dual-Counter Loop Filter for a Digital Phase Locked Loop

This block smooths the phase-error decisions of an all-digital phase locked loop before they reach the digitally controlled oscillator. It keeps two independent counters, both of modulus `KMOD` and both counting upward only. A single direction bit from the phase detector names which counter moves. One counter gathers "input leads" decisions and the other gathers "input lags" decisions. Each counter advances only on cycles where the K-clock enable is high. In a full loop that enable runs at a large integer multiple of the reference frequency, such as 8, 16 or 32 times.

Each counter drives one steering output from its most significant bit. `carry` is high while the advance counter holds a value of at least `KMOD/2`. `borrow` is high under the same rule for the retard counter. When the selected counter sits at `KMOD-1` and is stepped, it would reach `KMOD`. On that step both counters return to zero in the same cycle. This restarts the filter's integration window. `KMOD` must be a power of two between 8 and 65536.

Top module: `kloop_filter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both counters clear. Both `carry` and `borrow` read 0 after that edge.
- R2: On an edge with `kclk_en`=1 and `up_dn`=1, the advance counter increases by one and the retard counter is unchanged, unless a wrap occurs (R7).
- R3: On an edge with `kclk_en`=1 and `up_dn`=0, the retard counter increases by one and the advance counter is unchanged, unless a wrap occurs (R7).
- R4: On an edge with `kclk_en`=0, neither counter changes, whatever `up_dn` is.
- R5: `carry` is registered and equals bit `log2(KMOD)-1` of the advance counter. It is 1 exactly while that counter holds `KMOD/2` or more.
- R6: `borrow` is registered and equals bit `log2(KMOD)-1` of the retard counter. It is 1 exactly while that counter holds `KMOD/2` or more.
- R7: When the selected counter holds `KMOD-1` on an enabled edge, both counters become 0 after that edge. `carry` and `borrow` are then both 0.
- R8: After `up_dn` changes, the newly selected counter resumes from the value it held before, not from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| kclk_en | input | 1 | K-clock enable; counting happens only when high |
| up_dn | input | 1 | 1 selects the advance counter, 0 selects the retard counter |
| carry | output | 1 | Registered MSB of the advance counter |
| borrow | output | 1 | Registered MSB of the retard counter |

## Verification
Every cycle, the assertions check four things. A disabled edge leaves both counters still. An enabled edge moves only the selected counter by exactly one. A wrap clears both counters together. Each output flag matches the MSB of its counter.

Some behaviour can only be seen through the bench scenarios at the ports. These include the exact step count at which `carry` or `borrow` first rises, and resumption after a direction change. They also include the wrap clearing the idle counter, shown by `borrow` needing a full half range again after the wrap.

// File: rtl/kloop_pkg.sv
// Package: shared helpers for the dual-counter loop filter.
// Assumes: modulus values fit in 32 bits.
package kloop_pkg;

    // Number of counter channels in the filter (advance, retard)
    localparam int NUM_CH = 2;

    // Channel indices
    typedef enum logic {
        CH_ADV = 1'b0,
        CH_RET = 1'b1
    } kf_chan_e;

    // True when v is a power of two
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/kf_counter.sv
// Module: kf_counter
// What: one modulus-2^W up-counter with step and synchronous clear.
//       It exposes its current value, its next value and a top-of-range flag.
// Assumes: clear has priority over step; the counter wraps only by clear.
module kf_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clear,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         at_top
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Next-state selection: clear, step or hold
    always_comb begin
        if (clear)
            cnt_nxt = '0;
        else if (step)
            cnt_nxt = cnt + 1'b1;
        else
            cnt_nxt = cnt;
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    // Top-of-range decode for wrap detection
    assign at_top = (cnt == TOP);

    // A cycle with no step and no clear leaves the count alone
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(cnt)); // R4

    // A step without clear moves the count by exactly one
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (cnt == $past(cnt) + 1'b1)); // R2

endmodule

// File: rtl/kf_wrap_ctrl.sv
// Module: kf_wrap_ctrl
// What: turns the enable and direction bit into per-channel step strobes.
//       It raises a shared clear when the selected channel is at its top.
// Assumes: channel 0 is advance (up_dn=1), channel 1 is retard (up_dn=0).
module kf_wrap_ctrl
    import kloop_pkg::*;
(
    input  logic              en,
    input  logic              up_dn,
    input  logic [NUM_CH-1:0] top,
    output logic [NUM_CH-1:0] step,
    output logic              clear
);

    logic [NUM_CH-1:0] sel;

    // One-hot channel selection from the direction bit
    always_comb begin
        sel          = '0;
        sel[CH_ADV]  = up_dn;
        sel[CH_RET]  = !up_dn;
    end

    // Wrap when the selected channel is stepped from its top value
    assign clear = en && ((sel & top) != '0);

    // Step strobes, suppressed on a wrap cycle
    assign step = (en && !clear) ? sel : '0;

endmodule

// File: rtl/kf_flag_reg.sv
// Module: kf_flag_reg
// What: registers the MSB of a counter's next value as a steering flag.
//       The flag lines up with the counter register.
// Assumes: synchronous active-low reset, same clock as the counter.
module kf_flag_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] nxt,
    output logic         flag
);

    // Capture the half-range bit of the upcoming count
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else
            flag <= nxt[W-1];
    end

endmodule

// File: rtl/kloop_filter.sv
// Module: kloop_filter (top)
// What: dual up-counter loop filter. up_dn picks the counter to advance on
//       each enabled K-clock cycle. carry and borrow are the counters' MSBs.
//       A wrap of either counter clears both.
// Assumes: KMOD is a power of two in [8, 65536].
module kloop_filter
    import kloop_pkg::*;
#(
    parameter int KMOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kclk_en,
    input  logic up_dn,
    output logic carry,
    output logic borrow
);

    localparam int W = $clog2(KMOD);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Elaboration-time parameter guard
    generate
        if (!is_pow2(KMOD) || KMOD < 8 || KMOD > 65536) begin : g_bad_kmod
            $error("kloop_filter: KMOD must be a power of two in [8,65536]");
        end
    endgenerate

    logic [NUM_CH-1:0]         ch_step;
    logic [NUM_CH-1:0]         ch_top;
    logic                      wrap_clr;
    logic [NUM_CH-1:0][W-1:0]  ch_cnt;
    logic [NUM_CH-1:0][W-1:0]  ch_nxt;
    logic [NUM_CH-1:0]         ch_flag;

    kf_wrap_ctrl u_ctrl (
        .en    (kclk_en),
        .up_dn (up_dn),
        .top   (ch_top),
        .step  (ch_step),
        .clear (wrap_clr)
    );

    // One counter and one flag register per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        kf_counter #(.W(W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (ch_step[c]),
            .clear   (wrap_clr),
            .cnt     (ch_cnt[c]),
            .cnt_nxt (ch_nxt[c]),
            .at_top  (ch_top[c])
        );

        kf_flag_reg #(.W(W)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .nxt   (ch_nxt[c]),
            .flag  (ch_flag[c])
        );
    end

    assign carry  = ch_flag[CH_ADV];
    assign borrow = ch_flag[CH_RET];

    // Enabled advance step leaves the retard counter alone
    AST_ADV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (kclk_en && up_dn && ch_cnt[CH_ADV] != TOP)
        |=> (ch_cnt[CH_ADV] == $past(ch_cnt[CH_ADV]) + 1'b1)
            && $stable(ch_cnt[CH_RET])); // R2

    // Enabled retard step leaves the advance counter alone
    AST_RET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (kclk_en && !up_dn && ch_cnt[CH_RET] != TOP)
        |=> (ch_cnt[CH_RET] == $past(ch_cnt[CH_RET]) + 1'b1)
            && $stable(ch_cnt[CH_ADV])); // R3

    // Disabled cycles freeze both counters
    AST_NO_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !kclk_en |=> ($stable(ch_cnt[CH_ADV]) && $stable(ch_cnt[CH_RET]))); // R4

    // Stepping a full counter clears both
    AST_WRAP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (kclk_en && ((up_dn && ch_cnt[CH_ADV] == TOP) || (!up_dn && ch_cnt[CH_RET] == TOP)))
        |=> (ch_cnt[CH_ADV] == '0 && ch_cnt[CH_RET] == '0 && !carry && !borrow)); // R7

    // carry tracks the advance counter's half-range bit
    AST_CARRY_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        carry == ch_cnt[CH_ADV][W-1]); // R5

    // borrow tracks the retard counter's half-range bit
    AST_BORROW_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        borrow == ch_cnt[CH_RET][W-1]); // R6

endmodule

// File: tb/kloop_filter_test.sv
// Scoreboard bench for kloop_filter. The driver applies one cycle and pushes
// the modelled flags. The monitor pops and compares at the next falling edge.
module kloop_filter_test;

    localparam int K = 16;

    typedef struct {
        logic  c;
        logic  b;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kclk_en = 1'b0;
    logic up_dn = 1'b0;
    logic carry, borrow;

    int checks = 0;
    int errors = 0;
    int mu = 0;
    int md = 0;
    int cycles = 0;
    bit done = 0;
    exp_t sb[$];

    kloop_filter #(.KMOD(K)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .kclk_en(kclk_en),
        .up_dn  (up_dn),
        .carry  (carry),
        .borrow (borrow)
    );

    always #5 clk = ~clk;

    // Compare one pair of observed flags with the expected pair
    task automatic compare(input logic c, input logic b, input string req);
        checks++;
        if (carry !== c || borrow !== b) begin
            errors++;
            $display("FAIL %s: carry/borrow actual=%b%b expected=%b%b",
                     req, carry, borrow, c, b);
        end
    endtask

    // Apply one clock cycle, update the reference model, push the expectation
    task automatic cycle(input logic en, input logic dir, input string req);
        @(negedge clk);
        kclk_en = en;
        up_dn   = dir;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            mu = 0; md = 0;
        end else if (en) begin
            if (dir) begin
                if (mu == K-1) begin mu = 0; md = 0; end else mu++;
            end else begin
                if (md == K-1) begin mu = 0; md = 0; end else md++;
            end
        end
        sb.push_back('{c: (mu >= K/2), b: (md >= K/2), req: req});
    endtask

    // Monitor: pop and compare after each cycle
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compare(e.c, e.b, e.req);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        cycle(1'b1, 1'b1, "R1");
        cycle(1'b1, 1'b0, "R1");
        rst_n = 1'b1;

        // R2/R5: advance steps; carry rises on the eighth step
        for (int i = 0; i < 8; i++) cycle(1'b1, 1'b1, "R5");
        // R4: enable low, direction toggling, nothing moves
        for (int i = 0; i < 6; i++) cycle(1'b0, i[0], "R4");
        // R3/R6: retard steps; borrow rises, carry held
        for (int i = 0; i < 8; i++) cycle(1'b1, 1'b0, "R6");
        // R8: back to advance, resume from 8 up to 15
        for (int i = 0; i < 7; i++) cycle(1'b1, 1'b1, "R8");
        // R7: wrap from 15 clears both
        cycle(1'b1, 1'b1, "R7");
        // R7: retard restarted at 0, needs 8 steps again
        for (int i = 0; i < 8; i++) cycle(1'b1, 1'b0, "R7");
        // R3: further retard steps do not move carry
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, "R3");
        // R2: advance steps do not move borrow
        for (int i = 0; i < 9; i++) cycle(1'b1, 1'b1, "R2");
        // R1: reset with counters loaded
        rst_n = 1'b0;
        cycle(1'b1, 1'b1, "R1");
        rst_n = 1'b1;
        cycle(1'b0, 1'b1, "R1");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule